// File: doc/BRIEF.md
# Immediate Shift Executor

This block executes the immediate-shift group of a 32-bit RISC-style integer instruction set. It receives a raw 32-bit instruction word and the value of the first source register, decodes the word, and, if the word belongs to the shift group, shifts the operand by the 5-bit immediate amount: left with zero fill, right with zero fill, or right with the sign bit copied. It checks the seven upper bits of the word and flags any pattern the encoding does not allow.

The result, the destination register index, a write enable and an illegal flag are registered and appear one cycle after an input marked valid. Words from any other opcode, or from the same opcode with a non-shift function code, are reported only as foreign through a claim flag, with no write and no illegal flag, so a surrounding execute stage can route them elsewhere.

Top module: `imm_shift_exec`

## Requirements
- R1: A word is claimed (out_ours=1) only when bits [6:0] equal 7'b0010011 and bits [14:12] equal 3'b001 or 3'b101; any other word gives out_ours=0, out_wen=0, out_illegal=0, out_rd=0 and out_result=0.
- R2: With bits [14:12]=3'b001 and bits [31:25]=7'b0000000, the result is the operand shifted left by bits [24:20], with zeros entering the low-order bits.
- R3: With bits [14:12]=3'b101 and bits [31:25]=7'b0000000, the result is the operand shifted right by bits [24:20], with zeros entering the high-order bits.
- R4: With bits [14:12]=3'b101 and bits [31:25]=7'b0100000, the result is the operand shifted right by bits [24:20], with copies of operand bit 31 entering the high-order bits.
- R5: A claimed word is illegal when bits [31:25] are nonzero for the left shift, or are neither 7'b0000000 nor 7'b0100000 for the right shift; it then gives out_illegal=1, out_wen=0 and out_result=0.
- R6: A shift amount of 0 returns the operand unchanged for all three legal shift kinds.
- R7: For a claimed word out_rd equals bits [11:7]; out_wen is 1 exactly when the word is a legal shift and bits [11:7] are nonzero.
- R8: An input sampled with in_valid=1 produces out_valid=1 and its results on the next clock edge; a cycle with in_valid=0 produces out_valid=0 with every other output 0 on the next edge.
- R9: A synchronous active-high reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operand are present this cycle |
| in_instr | input | 32 | Raw instruction word |
| in_operand | input | 32 | Value of the first source register |
| out_valid | output | 1 | Registered outputs belong to an accepted input |
| out_ours | output | 1 | Word belongs to the immediate-shift group |
| out_illegal | output | 1 | Claimed word has a malformed upper field |
| out_wen | output | 1 | Destination register should be written |
| out_rd | output | 5 | Destination register index |
| out_result | output | 32 | Shifted value |

## Verification
Two suppressors of the register write can land in the same cycle: an illegal upper field and a destination index of zero. The bench sweeps all 128 upper-field patterns for both function codes once with a nonzero destination and once with destination zero, and judges that the illegal flag still rises when the zero index would already block the write, while out_wen stays low in both cases. The legal sweep also covers every shift amount for all three kinds with destination indices that include zero, so a legal shift to index zero is judged as claimed, not illegal, with no write.

// File: rtl/imm_shift_pkg.sv
package imm_shift_pkg;

  localparam int INSTR_W   = 32;
  localparam int SHAMT_W   = 5;
  localparam int REGIDX_W  = 5;
  localparam int OPC_W     = 7;
  localparam int FN3_W     = 3;
  localparam int UPPER_W   = 7;

  localparam logic [OPC_W-1:0]   OPC_IMM_ALU = 7'b0010011;
  localparam logic [FN3_W-1:0]   FN3_SHL     = 3'b001;
  localparam logic [FN3_W-1:0]   FN3_SHR     = 3'b101;
  localparam logic [UPPER_W-1:0] UPPER_PLAIN = 7'b0000000;
  localparam logic [UPPER_W-1:0] UPPER_ARITH = 7'b0100000;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_LEFT  = 2'd1,
    KIND_RLOG  = 2'd2,
    KIND_RARI  = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic                ours;
    logic                illegal;
    shift_kind_e         kind;
    logic [SHAMT_W-1:0]  amt;
    logic [REGIDX_W-1:0] rd;
  } shift_dec_t;

endpackage

// File: rtl/ishf_decode.sv
module ishf_decode
  import imm_shift_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output shift_dec_t         dec
);

  logic [OPC_W-1:0]   opc;
  logic [FN3_W-1:0]   fn3;
  logic [UPPER_W-1:0] upper;
  logic               grp;
  logic               want_left;
  logic               want_right;
  logic               ok_left;
  logic               ok_rlog;
  logic               ok_rari;

  assign opc   = instr[6:0];
  assign fn3   = instr[14:12];
  assign upper = instr[31:25];

  assign grp        = (opc == OPC_IMM_ALU);
  assign want_left  = grp && (fn3 == FN3_SHL);
  assign want_right = grp && (fn3 == FN3_SHR);

  assign ok_left = want_left  && (upper == UPPER_PLAIN);
  assign ok_rlog = want_right && (upper == UPPER_PLAIN);
  assign ok_rari = want_right && (upper == UPPER_ARITH);

  always_comb begin
    dec         = '0;
    dec.ours    = want_left || want_right;
    dec.illegal = (want_left || want_right) && !(ok_left || ok_rlog || ok_rari);
    dec.amt     = instr[24:20];
    dec.rd      = instr[11:7];
    if (ok_left)      dec.kind = KIND_LEFT;
    else if (ok_rlog) dec.kind = KIND_RLOG;
    else if (ok_rari) dec.kind = KIND_RARI;
    else              dec.kind = KIND_NONE;
  end

  // R5: at most one legal interpretation per word
  always_comb begin
    assert_one_kind_R5: assert ($onehot0({ok_left, ok_rlog, ok_rari}));
  end

endmodule

// File: rtl/ishf_barrel.sv
module ishf_barrel #(
  parameter int XLEN = 32,
  parameter int AW   = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] opnd,
  input  logic [AW-1:0]   amt,
  input  logic            dir_left,
  input  logic            arith,
  output logic [XLEN-1:0] res
);

  logic [XLEN-1:0] pre;
  logic [XLEN-1:0] rev_out;
  logic            fill;
  logic [XLEN-1:0] stg [AW+1];

  // left shifts reuse the right-shift network on a bit-reversed operand
  for (genvar b = 0; b < XLEN; b++) begin : g_rev_in
    assign pre[b] = dir_left ? opnd[XLEN-1-b] : opnd[b];
  end

  assign fill   = arith && !dir_left && opnd[XLEN-1];
  assign stg[0] = pre;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stg[s+1] = amt[s] ? {{STEP{fill}}, stg[s][XLEN-1:STEP]} : stg[s];
  end

  for (genvar b = 0; b < XLEN; b++) begin : g_rev_out
    assign rev_out[b] = stg[AW][XLEN-1-b];
  end

  assign res = dir_left ? rev_out : stg[AW];

  // R6: zero amount passes operand through
  always_comb begin
    if (amt == '0) assert_zero_pass_R6: assert (res == opnd);
  end

  // R2: left shift by a nonzero amount always vacates bit 0
  always_comb begin
    if (dir_left && amt != '0) assert_left_lsb_R2: assert (res[0] == 1'b0);
  end

endmodule

// File: rtl/imm_shift_exec.sv
module imm_shift_exec
  import imm_shift_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [INSTR_W-1:0]  in_instr,
  input  logic [XLEN-1:0]     in_operand,
  output logic                out_valid,
  output logic                out_ours,
  output logic                out_illegal,
  output logic                out_wen,
  output logic [REGIDX_W-1:0] out_rd,
  output logic [XLEN-1:0]     out_result
);

  shift_dec_t      dec;
  logic [XLEN-1:0] shifted;
  logic            legal;

  ishf_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  ishf_barrel #(
    .XLEN (XLEN),
    .AW   (SHAMT_W)
  ) u_sh (
    .opnd     (in_operand),
    .amt      (dec.amt),
    .dir_left (dec.kind == KIND_LEFT),
    .arith    (dec.kind == KIND_RARI),
    .res      (shifted)
  );

  assign legal = dec.ours && !dec.illegal;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_ours    <= 1'b0;
      out_illegal <= 1'b0;
      out_wen     <= 1'b0;
      out_rd      <= '0;
      out_result  <= '0;
    end else if (in_valid) begin
      out_valid   <= 1'b1;
      out_ours    <= dec.ours;
      out_illegal <= dec.illegal;
      out_wen     <= legal && (dec.rd != '0);
      out_rd      <= dec.ours ? dec.rd : '0;
      out_result  <= legal ? shifted : '0;
    end else begin
      out_valid   <= 1'b0;
      out_ours    <= 1'b0;
      out_illegal <= 1'b0;
      out_wen     <= 1'b0;
      out_rd      <= '0;
      out_result  <= '0;
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_wen && !out_illegal && !out_ours));

  assert_wen_needs_rd_R7: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> (out_rd != '0 && out_ours && out_valid));

  assert_illegal_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (!out_wen && out_ours && out_result == '0));

  assert_foreign_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ours) |-> (!out_wen && !out_illegal && out_rd == '0));

endmodule

// File: tb/sim_imm_shift_exec.sv
`timescale 1ns/1ps
module sim_imm_shift_exec;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_instr;
  logic [31:0] in_operand;
  logic        out_valid, out_ours, out_illegal, out_wen;
  logic [4:0]  out_rd;
  logic [31:0] out_result;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  imm_shift_exec u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_operand(in_operand), .out_valid(out_valid), .out_ours(out_ours),
    .out_illegal(out_illegal), .out_wen(out_wen), .out_rd(out_rd),
    .out_result(out_result)
  );

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] up, input logic [4:0] sh,
                                     input logic [4:0] rs, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [6:0] opc);
    return {up, sh, rs, f3, rd, opc};
  endfunction

  // drive one valid word, check on the following negedge
  task automatic run_one(input logic [31:0] ins, input logic [31:0] op);
    logic        e_ours, e_ill, e_wen;
    logic [4:0]  e_rd, sh;
    logic [31:0] e_res;
    string       rq;
    @(negedge clk);
    in_valid = 1'b1; in_instr = ins; in_operand = op;
    sh     = ins[24:20];
    e_ours = (ins[6:0] == 7'h13) && (ins[14:12] == 3'b001 || ins[14:12] == 3'b101);
    e_ill  = 1'b0; e_res = 32'h0; rq = "R1";
    if (e_ours) begin
      if (ins[14:12] == 3'b001) begin
        if (ins[31:25] != 7'h00) begin e_ill = 1'b1; rq = "R5"; end
        else begin e_res = op << sh; rq = "R2"; end
      end else begin
        if (ins[31:25] == 7'h00) begin e_res = op >> sh; rq = "R3"; end
        else if (ins[31:25] == 7'h20) begin e_res = 32'($signed(op) >>> sh); rq = "R4"; end
        else begin e_ill = 1'b1; rq = "R5"; end
      end
      if (!e_ill && sh == 5'd0) rq = "R6";
    end
    e_rd  = e_ours ? ins[11:7] : 5'd0;
    e_wen = e_ours && !e_ill && (ins[11:7] != 5'd0);
    @(negedge clk);
    cmp("R8", "out_valid", {31'b0, out_valid}, 32'd1);
    cmp("R1", "out_ours", {31'b0, out_ours}, {31'b0, e_ours});
    cmp("R5", "out_illegal", {31'b0, out_illegal}, {31'b0, e_ill});
    cmp("R7", "out_wen", {31'b0, out_wen}, {31'b0, e_wen});
    cmp("R7", "out_rd", {27'b0, out_rd}, {27'b0, e_rd});
    cmp(rq, "out_result", out_result, e_res);
    in_valid = 1'b0;
  endtask

  task automatic check_quiet(input string req);
    cmp(req, "out_valid", {31'b0, out_valid}, 32'd0);
    cmp(req, "flags", {29'b0, out_ours, out_illegal, out_wen}, 32'd0);
    cmp(req, "out_rd", {27'b0, out_rd}, 32'd0);
    cmp(req, "out_result", out_result, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [31:0] ops [5];
    ops[0] = 32'h8000_0001; ops[1] = 32'hFFFF_FFFF; ops[2] = 32'h7FFF_FFFF;
    ops[3] = 32'hA5C3_1E69; ops[4] = 32'h0000_0000;
    rst = 1'b1; in_valid = 1'b0; in_instr = '0; in_operand = '0;
    repeat (3) @(negedge clk);
    check_quiet("R9");
    rst = 1'b0;

    // R2 R3 R4 R6: all amounts, all legal kinds
    for (int k = 0; k < 3; k++) begin
      for (int s = 0; s < 32; s++) begin
        for (int p = 0; p < 6; p++) begin
          logic [31:0] op;
          logic [6:0]  up;
          logic [2:0]  f3;
          op = (p < 5) ? ops[p] : (32'h9E37_79B9 * (k + 1)) ^ 32'(s);
          up = (k == 2) ? 7'h20 : 7'h00;
          f3 = (k == 0) ? 3'b001 : 3'b101;
          run_one(mk(up, 5'(s), 5'(p), f3, 5'((s * 7 + k + p) % 32), 7'h13), op);
        end
      end
    end

    // R5 R7: every upper pattern, nonzero and zero destination
    for (int u = 0; u < 128; u++) begin
      run_one(mk(7'(u), 5'(u % 32), 5'd3, 3'b001, 5'((u % 31) + 1), 7'h13), 32'hC001_D00D);
      run_one(mk(7'(u), 5'(u % 32), 5'd3, 3'b101, 5'((u % 31) + 1), 7'h13), 32'h8123_4567);
      run_one(mk(7'(u), 5'(u % 32), 5'd3, 3'b001, 5'd0, 7'h13), 32'h1357_9BDF);
      run_one(mk(7'(u), 5'(u % 32), 5'd3, 3'b101, 5'd0, 7'h13), 32'hF000_000F);
    end

    // R1: other function codes and other opcodes
    for (int f = 0; f < 8; f++) begin
      run_one(mk(7'h00, 5'd4, 5'd1, 3'(f), 5'd9, 7'h13), 32'h0000_00FF);
      run_one(mk(7'h00, 5'd4, 5'd1, 3'(f), 5'd9, 7'h33), 32'h0000_00FF);
      run_one(mk(7'h20, 5'd4, 5'd1, 3'(f), 5'd9, 7'h1B), 32'h8000_00FF);
      run_one(mk(7'h00, 5'd4, 5'd1, 3'(f), 5'd9, 7'h17), 32'h0000_00FF);
    end

    // R8: idle cycle with a legal word on the inputs
    @(negedge clk);
    in_valid = 1'b0; in_instr = mk(7'h00, 5'd1, 5'd1, 3'b001, 5'd5, 7'h13); in_operand = 32'h1;
    @(negedge clk);
    check_quiet("R8");

    // R9: reset following a legal write
    run_one(mk(7'h00, 5'd2, 5'd1, 3'b001, 5'd6, 7'h13), 32'h3);
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check_quiet("R9");
    rst = 1'b0; in_valid = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule